// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is one output cell of a programmable sum-of-products logic core. It takes a group of product terms from the array, ORs them into a sum, and applies a per-cell polarity choice. A two-bit architecture code then sets how the sum reaches the pin. The sum can pass through a D flip-flop, drive the pin combinationally under a direction term, be held off so the pin acts as an input, or drive the pin at all times. The cell outputs a pin data bit, a pin drive enable, and a feedback bit that goes back into the array.

The flip-flop has four controls. An asynchronous clear term acts at once. A synchronous set term acts on the next rising clock edge. A power-up clear holds the flip-flop low while reset is high and for a fixed number of clocks after reset is released. A diagnostic preload, active while two test inputs are both high, captures the pin value into the flip-flop on each clock. In registered mode the pin shows the inverse of the flip-flop, so a cleared register reads high on the pin whatever the polarity setting.

Top module: `omc_cell`

## Requirements
- R1: With `arch_i` = 2'b11 (registered), `pin_out_o` is the inverse of the flip-flop, `fb_o` is the flip-flop, and `pin_oe_o` equals `glob_oe_i`.
- R2: With `arch_i` = 2'b00 (bidirectional), `pin_out_o` is the polarized sum, `pin_oe_o` equals `dir_term_i`, and `fb_o` equals `pin_in_i`.
- R3: With `arch_i` = 2'b01 (fixed input), `pin_oe_o` is 0 and `fb_o` equals `pin_in_i`.
- R4: With `arch_i` = 2'b10 (fixed output), `pin_oe_o` is 1, `fb_o` is 0, and `pin_out_o` is the polarized sum.
- R5: The sum is the OR of all `term_i` bits. With `pol_i` = 0 the output is inverted: the combinational pin shows NOT sum, and in registered mode the pin shows NOT sum after the clock edge. With `pol_i` = 1 both show the sum unchanged.
- R6: While `ar_term_i` is high the flip-flop is 0 at once, with no clock edge needed.
- R7: When `sp_term_i` is high at a rising edge, the flip-flop becomes 1 at that edge and not before.
- R8: While `rst` is high, and for PUR_CYCLES (default 4) rising edges after it falls, the flip-flop is held at 0. A registered pin therefore reads 1 for either polarity. The data input is first captured at the next edge after that.
- R9: While `test_a_i` and `test_b_i` are both high, `pin_oe_o` is 0 and each edge loads `pin_in_i` into the flip-flop. After the mode is left, the pin shows the inverse of the loaded value and `fb_o` shows the loaded value. With only one test input high, no preload takes place.
- R10: The flip-flop controls have a fixed priority: asynchronous clear first, then power-up clear, then preload, then synchronous set, then data. In particular, a clear and a set that are high together leave the flip-flop at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell flip-flop |
| rst | input | 1 | Synchronous active-high power-up reset |
| term_i | input | NUM_TERMS | Product terms ORed into the sum |
| dir_term_i | input | 1 | Direction product term (drive enable in bidirectional mode) |
| sp_term_i | input | 1 | Shared synchronous set term |
| ar_term_i | input | 1 | Shared asynchronous clear term |
| glob_oe_i | input | 1 | Common output enable for registered cells |
| arch_i | input | 2 | Architecture code: 11 registered, 00 bidirectional, 01 fixed input, 10 fixed output |
| pol_i | input | 1 | 1 non-inverting, 0 inverting |
| test_a_i | input | 1 | First preload test input |
| test_b_i | input | 1 | Second preload test input |
| pin_in_i | input | 1 | Value currently seen on the pin |
| pin_out_o | output | 1 | Data driven to the pin |
| pin_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback into the array |

## Verification
The assertions check on every cycle the properties that need no stimulus history. The fixed-input pin is never driven. In fixed-output mode the pin is always driven and the feedback stays low. In registered mode the pin is the inverse of the feedback. Preload holds the pin undriven, the asynchronous clear holds the register low, and power-up, set and preload each produce the expected register value one edge later. Only the bench scenarios can show the rest. These are the full mapping from sum and polarity to the pin across every mode, the exact edge on which power-up release first captures data, and that a set waits for the clock. They also cover a clear taking effect between edges and a preload value surviving the return to normal operation.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic [1:0] {
        MODE_BIDIR   = 2'b00,
        MODE_FIXIN   = 2'b01,
        MODE_FIXOUT  = 2'b10,
        MODE_REG     = 2'b11
    } omc_mode_e;

    typedef struct packed {
        logic data;
        logic en;
        logic fb;
    } omc_pin_t;

    // Apply output polarity: pol=1 keeps the value, pol=0 inverts it.
    function automatic logic apply_pol(input logic val, input logic pol);
        return pol ? val : ~val;
    endfunction

    // Register data input, chosen so the inverted pin buffer yields apply_pol(sum).
    function automatic logic reg_d(input logic sum, input logic pol);
        return ~apply_pol(sum, pol);
    endfunction

endpackage

// File: rtl/omc_sum.sv
module omc_sum
    import omc_pkg::*;
#(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] term_i,
    input  logic                 pol_i,
    output logic                 comb_o,
    output logic                 d_o
);
    localparam int STAGES = NUM_TERMS;

    logic [STAGES:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < STAGES; g++) begin : g_or
        assign chain[g+1] = chain[g] | term_i[g];
    end

    assign comb_o = apply_pol(chain[STAGES], pol_i);
    assign d_o    = reg_d(chain[STAGES], pol_i);

endmodule

// File: rtl/omc_por.sv
module omc_por #(
    parameter int PUR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic por_o
);
    localparam int CW = $clog2(PUR_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PUR_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign por_o = rst | (cnt != LIMIT);

endmodule

// File: rtl/omc_dreg.sv
module omc_dreg (
    input  logic clk,
    input  logic rst_i,
    input  logic ar_i,
    input  logic por_i,
    input  logic pl_i,
    input  logic pl_data_i,
    input  logic sp_i,
    input  logic d_i,
    output logic q_o
);
    // Priority: async clear, power-up clear, preload, sync set, data (R10)
    always_ff @(posedge clk or posedge ar_i) begin
        if (ar_i) begin
            q_o <= 1'b0;
        end else if (por_i) begin
            q_o <= 1'b0;
        end else if (pl_i) begin
            q_o <= pl_data_i;
        end else if (sp_i) begin
            q_o <= 1'b1;
        end else begin
            q_o <= d_i;
        end
    end

    AST_AR_CLEARS: assert property (@(posedge clk) disable iff (rst_i)
        ar_i |-> !q_o); // R6

    AST_POR_HOLDS: assert property (@(posedge clk) disable iff (rst_i)
        por_i |=> !q_o); // R8

    AST_SP_SETS: assert property (@(posedge clk) disable iff (rst_i)
        (sp_i && !ar_i && !por_i && !pl_i) |=> (q_o || ar_i)); // R7

    AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (rst_i)
        (pl_i && !ar_i && !por_i) |=> ((q_o == $past(pl_data_i)) || ar_i)); // R9

endmodule

// File: rtl/omc_cell.sv
module omc_cell
    import omc_pkg::*;
#(
    parameter int NUM_TERMS  = 8,
    parameter int PUR_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TERMS-1:0] term_i,
    input  logic                 dir_term_i,
    input  logic                 sp_term_i,
    input  logic                 ar_term_i,
    input  logic                 glob_oe_i,
    input  logic [1:0]           arch_i,
    input  logic                 pol_i,
    input  logic                 test_a_i,
    input  logic                 test_b_i,
    input  logic                 pin_in_i,
    output logic                 pin_out_o,
    output logic                 pin_oe_o,
    output logic                 fb_o
);
    omc_mode_e mode;
    logic      preload;
    logic      comb_val;
    logic      d_val;
    logic      por;
    logic      q;
    omc_pin_t  drv;

    assign mode    = omc_mode_e'(arch_i);
    assign preload = test_a_i & test_b_i;

    omc_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .term_i (term_i),
        .pol_i  (pol_i),
        .comb_o (comb_val),
        .d_o    (d_val)
    );

    omc_por #(.PUR_CYCLES(PUR_CYCLES)) u_por (
        .clk   (clk),
        .rst   (rst),
        .por_o (por)
    );

    omc_dreg u_dreg (
        .clk       (clk),
        .rst_i     (rst),
        .ar_i      (ar_term_i),
        .por_i     (por),
        .pl_i      (preload),
        .pl_data_i (pin_in_i),
        .sp_i      (sp_term_i),
        .d_i       (d_val),
        .q_o       (q)
    );

    always_comb begin
        unique case (mode)
            MODE_REG:    drv = '{data: ~q,       en: glob_oe_i,  fb: q};
            MODE_BIDIR:  drv = '{data: comb_val, en: dir_term_i, fb: pin_in_i};
            MODE_FIXIN:  drv = '{data: comb_val, en: 1'b0,       fb: pin_in_i};
            default:     drv = '{data: comb_val, en: 1'b1,       fb: 1'b0};
        endcase
        if (preload) begin
            drv.en = 1'b0;
        end
    end

    assign pin_out_o = drv.data;
    assign pin_oe_o  = drv.en;
    assign fb_o      = drv.fb;

    AST_FIXIN_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FIXIN) |-> !pin_oe_o); // R3

    AST_FIXOUT_FB_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FIXOUT && !preload) |-> (pin_oe_o && !fb_o)); // R4

    AST_REG_PIN_INVERTED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REG) |-> (pin_out_o != fb_o)); // R1

    AST_PRELOAD_HIZ: assert property (@(posedge clk) disable iff (rst)
        preload |-> !pin_oe_o); // R9

endmodule

// File: tb/omc_cell_tb.sv
`timescale 1ns/1ps
module omc_cell_tb;
    localparam int NT  = 8;
    localparam int PUR = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NT-1:0] term;
    logic          dir_t, sp_t, ar_t, goe, pol, ta, tb_t, pin_in;
    logic [1:0]    arch;
    logic          pin_out, pin_oe, fb;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    omc_cell #(.NUM_TERMS(NT), .PUR_CYCLES(PUR)) u_dut (
        .clk(clk), .rst(rst), .term_i(term), .dir_term_i(dir_t),
        .sp_term_i(sp_t), .ar_term_i(ar_t), .glob_oe_i(goe), .arch_i(arch),
        .pol_i(pol), .test_a_i(ta), .test_b_i(tb_t), .pin_in_i(pin_in),
        .pin_out_o(pin_out), .pin_oe_o(pin_oe), .fb_o(fb)
    );

    // act/exp packed as {pin_out, pin_oe, fb}
    task automatic chk(input string tag, input logic [2:0] exp, input logic [2:0] mask);
        logic [2:0] act;
        act = {pin_out, pin_oe, fb};
        n_checks++;
        if ((act & mask) !== (exp & mask)) begin
            n_fail++;
            $display("FAIL %s: actual {out,oe,fb}=%b expected %b (mask %b)", tag, act, exp, mask);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1; term = '1; dir_t = 0; sp_t = 0; ar_t = 0; goe = 1; pol = 0;
        ta = 0; tb_t = 0; pin_in = 0; arch = 2'b11;

        // R8: register cleared during reset, pin high for both polarities
        step(); step();
        chk("R8 reset pol0", 3'b110, 3'b111);
        pol = 1; term = '0;   // D would be 1
        step();
        chk("R8 reset pol1", 3'b110, 3'b111);
        rst = 0;
        for (int i = 0; i < PUR; i++) begin
            step();
            chk("R8 power-up hold", 3'b110, 3'b111);
        end
        step();
        chk("R8 first capture", 3'b011, 3'b111);

        // R1 R5: registered sweep
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 256; t++) begin
                for (int g = 0; g < 2; g++) begin
                    logic s, q;
                    pol = p[0]; term = t[NT-1:0]; goe = g[0];
                    s = (t != 0);
                    q = p[0] ? ~s : s;
                    step();
                    chk("R1 R5 registered", {~q, g[0], q}, 3'b111);
                end
            end
        end
        goe = 1;

        // R7: synchronous set
        pol = 0; term = '0; step();
        chk("R7 pre", 3'b110, 3'b111);
        sp_t = 1; #1;
        chk("R7 waits for edge", 3'b110, 3'b111);
        step();
        chk("R7 set at edge", 3'b011, 3'b111);
        sp_t = 0; step();
        chk("R7 released", 3'b110, 3'b111);

        // R6 R10: async clear
        term = '1; step();
        chk("R6 pre set", 3'b011, 3'b111);
        ar_t = 1; #1;
        chk("R6 immediate clear", 3'b110, 3'b111);
        sp_t = 1; step();
        chk("R10 clear beats set", 3'b110, 3'b111);
        ar_t = 0; sp_t = 0; #1;
        step();
        chk("R6 released capture", 3'b011, 3'b111);

        // R9: preload
        term = '0;            // D = 0
        ta = 1; tb_t = 1; pin_in = 1; #1;
        chk("R9 hiz in preload", 3'b000, 3'b010);
        step();
        ta = 0; tb_t = 0; pin_in = 0; #1;
        chk("R9 loaded one", 3'b011, 3'b111);
        step();               // D=0 captured
        term = '1;            // D = 1
        ta = 1; tb_t = 1; pin_in = 0;
        step();
        ta = 0; tb_t = 0; #1;
        chk("R9 loaded zero", 3'b110, 3'b111);
        term = '0; step();    // Q = 0
        ta = 1; tb_t = 0; pin_in = 1;
        step();
        chk("R9 single test input no preload", 3'b110, 3'b111);
        ta = 0;

        // R2 R3 R4 R5: combinational mode sweep
        for (int m = 0; m < 3; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int t = 0; t < 256; t++) begin
                    for (int d = 0; d < 4; d++) begin
                        logic s, o;
                        arch = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
                        pol = p[0]; term = t[NT-1:0]; dir_t = d[0]; pin_in = d[1];
                        s = (t != 0);
                        o = p[0] ? s : ~s;
                        #1;
                        if (m == 0)      chk("R2 R5 bidirectional", {o, d[0], d[1]}, 3'b111);
                        else if (m == 1) chk("R3 fixed input", {1'b0, 1'b0, d[1]}, 3'b011);
                        else             chk("R4 R5 fixed output", {o, 1'b1, 1'b0}, 3'b111);
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule